// File: doc/BRIEF.md
# Inline Register-to-Memory Write Engine

This engine sits on a command stream of register writes, each a method index with a 32-bit value, and turns that stream into 32-bit memory writes. Configuration methods set a 64-bit destination base address, an origin (x, y, z) and a transfer size given as a line length in bytes times a line count. A write to the execute method arms a transfer and rewinds a word offset to zero. Each later write to the data method launches one memory write at base + 4 × offset. The offset advances once the memory side accepts that word.

The memory side is a valid/ready write request. While a request waits for ready, the engine holds it unchanged and stops taking commands. Only linear destinations with a zero origin are accepted. A data write under any other setup is dropped and sets a sticky configuration error. A method index beyond the register space sets a separate sticky error. The done output rises once the number of words written covers the requested size.

The sequencer has two states. S_IDLE accepts commands. S_ISSUE presents one write request. The transition LAUNCH (S_IDLE to S_ISSUE) fires on an accepted data write with a legal setup. RETIRE (S_ISSUE to S_IDLE) fires when the memory side raises ready. A REJECT, which is a data write with an illegal setup, leaves the state at S_IDLE. Method indices that have no effect (pitch, block dimensions, width, height, depth and unused slots) are accepted and discarded.

Top module: `inline_wr_engine`

## Requirements
- R1: After reset, cmd_ready is 1, and mem_req_valid, done, err_cfg and err_method are all 0.
- R2: A data write (method 0x6D) with a legal setup produces one request whose data equals the written value. Its address is {high word at method 0x62, low word at method 0x63} + 4 × offset, with a carry from the low word into the high word.
- R3: Each accepted memory write increments the word offset by exactly one, so successive data writes target consecutive word addresses.
- R4: Any write to the execute method (0x6C) resets the word offset to zero, whatever its value.
- R5: While mem_req_valid is 1 and mem_req_ready is 0, the request address and data stay unchanged, cmd_ready stays 0 and the offset does not advance.
- R6: A data write is rejected when bit 0 of the execute value is 0, or when z (0x69), x (0x6A) or y (0x6B) is nonzero. A rejected write issues no request, leaves the offset unchanged and sets err_cfg, which stays set until reset.
- R7: A method index of 0x7F or above sets err_method, which stays set until reset. Such a command has no other effect.
- R8: A legal method other than 0x60–0x63, 0x69–0x6D has no effect on requests, offset, done or the error flags.
- R9: done is 1 exactly when an execute write has been seen since reset and offset ≥ floor(len × count / 4), where len is the value at method 0x60 and count is the value at method 0x61.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine accepts a command this cycle |
| cmd_method | input | 8 | Method index in 32-bit words |
| cmd_data | input | 32 | Value written to the method |
| mem_req_valid | output | 1 | Memory write request present |
| mem_req_ready | input | 1 | Memory side accepts the request |
| mem_req_addr | output | 64 | Byte address of the word write |
| mem_req_data | output | 32 | Word to write |
| done | output | 1 | Requested word count reached |
| err_cfg | output | 1 | Sticky: a data write was rejected by the setup check |
| err_method | output | 1 | Sticky: a method index was out of range |

## Verification
The bench sweeps stream lengths, two line-length/count splits and two base addresses, one of them with a low word near its top. A design that dropped the carry into the high address word would then emit wrapped addresses partway through a stream. Each sweep point also runs with a memory side that withholds ready for several cycles. A design that advanced the offset or changed the address on a stalled request would skip or duplicate words, and one that kept taking commands while stalled would overwrite the pending data. The bench covers a re-execute in mid-stream and rejected writes between good ones, which catch an offset that moves on a rejection. It also covers a byte count that is not a multiple of four and a zero size, so a done flag using ceiling division, strict equality or no armed condition shows up as a mismatch.

// File: rtl/iwe_pkg.sv
package iwe_pkg;
    localparam int unsigned NUM_METHODS = 'h7F;

    localparam int unsigned M_LINE_LEN = 'h60;
    localparam int unsigned M_LINE_CNT = 'h61;
    localparam int unsigned M_DST_HI   = 'h62;
    localparam int unsigned M_DST_LO   = 'h63;
    localparam int unsigned M_ORG_Z    = 'h69;
    localparam int unsigned M_ORG_X    = 'h6A;
    localparam int unsigned M_ORG_Y    = 'h6B;
    localparam int unsigned M_EXEC     = 'h6C;
    localparam int unsigned M_DATA     = 'h6D;

    typedef enum logic [0:0] {
        S_IDLE  = 1'b0,
        S_ISSUE = 1'b1
    } seq_state_e;
endpackage

// File: rtl/iwe_cfg_regs.sv
module iwe_cfg_regs
    import iwe_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned METH_W = 8,
    localparam int unsigned ADDR_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [METH_W-1:0] wr_method,
    input  logic [WORD_W-1:0] wr_data,
    output logic [ADDR_W-1:0] base_addr,
    output logic [WORD_W-1:0] line_len,
    output logic [WORD_W-1:0] line_cnt,
    output logic              exec_linear,
    output logic              origin_zero,
    output logic [WORD_W-1:0] data_word
);
    logic [WORD_W-1:0] len_q, cnt_q, hi_q, lo_q, z_q, x_q, y_q, data_q;
    logic              lin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q  <= '0;
            cnt_q  <= '0;
            hi_q   <= '0;
            lo_q   <= '0;
            z_q    <= '0;
            x_q    <= '0;
            y_q    <= '0;
            data_q <= '0;
            lin_q  <= 1'b0;
        end else if (wr_en) begin
            case (wr_method)
                METH_W'(M_LINE_LEN): len_q  <= wr_data;
                METH_W'(M_LINE_CNT): cnt_q  <= wr_data;
                METH_W'(M_DST_HI):   hi_q   <= wr_data;
                METH_W'(M_DST_LO):   lo_q   <= wr_data;
                METH_W'(M_ORG_Z):    z_q    <= wr_data;
                METH_W'(M_ORG_X):    x_q    <= wr_data;
                METH_W'(M_ORG_Y):    y_q    <= wr_data;
                METH_W'(M_EXEC):     lin_q  <= wr_data[0];
                METH_W'(M_DATA):     data_q <= wr_data;
                default: ;
            endcase
        end
    end

    assign base_addr   = {hi_q, lo_q};
    assign line_len    = len_q;
    assign line_cnt    = cnt_q;
    assign exec_linear = lin_q;
    assign origin_zero = ~|{z_q, x_q, y_q};
    assign data_word   = data_q;

    AST_HI_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_method == METH_W'(M_DST_HI) |=> base_addr[ADDR_W-1:WORD_W] == $past(wr_data))
        else $error("high address word not placed in upper half"); // R2

    AST_EXEC_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_method == METH_W'(M_EXEC) |=> exec_linear == $past(wr_data[0]))
        else $error("linear select not taken from bit 0"); // R6
endmodule

// File: rtl/iwe_seq.sv
module iwe_seq
    import iwe_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned METH_W = 8,
    parameter int unsigned OFS_W  = 32,
    localparam int unsigned ADDR_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [METH_W-1:0] cmd_method,
    output logic              cmd_ready,
    output logic              cmd_fire,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [WORD_W-1:0] line_len,
    input  logic [WORD_W-1:0] line_cnt,
    input  logic              exec_linear,
    input  logic              origin_zero,
    input  logic [WORD_W-1:0] data_word,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [WORD_W-1:0] mem_req_data,
    output logic              done,
    output logic              err_cfg,
    output logic              err_method
);
    seq_state_e state_q, state_d;
    logic [OFS_W-1:0]  offset_q;
    logic              armed_q;
    logic              is_data, is_exec, in_range, cfg_ok, launch, reject, retire;
    logic [ADDR_W-1:0] total_bytes, target_words;

    assign cmd_fire = cmd_valid && cmd_ready;
    assign is_data  = cmd_method == METH_W'(M_DATA);
    assign is_exec  = cmd_method == METH_W'(M_EXEC);
    assign in_range = cmd_method < METH_W'(NUM_METHODS);
    assign cfg_ok   = exec_linear && origin_zero;
    assign launch   = cmd_fire && is_data && cfg_ok;
    assign reject   = cmd_fire && is_data && !cfg_ok;
    assign retire   = mem_req_valid && mem_req_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (launch)        state_d = S_ISSUE;  // LAUNCH
            S_ISSUE: if (mem_req_ready) state_d = S_IDLE;   // RETIRE
            default:                    state_d = S_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        cmd_ready     = 1'b0;
        mem_req_valid = 1'b0;
        unique case (state_q)
            S_IDLE:  cmd_ready     = 1'b1;
            S_ISSUE: mem_req_valid = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            offset_q   <= '0;
            armed_q    <= 1'b0;
            err_cfg    <= 1'b0;
            err_method <= 1'b0;
        end else begin
            if (cmd_fire && is_exec) begin
                offset_q <= '0;
                armed_q  <= 1'b1;
            end else if (retire) begin
                offset_q <= offset_q + OFS_W'(1);
            end
            if (reject)                err_cfg    <= 1'b1;
            if (cmd_fire && !in_range) err_method <= 1'b1;
        end
    end

    assign mem_req_addr = base_addr + (ADDR_W'(offset_q) << 2);
    assign mem_req_data = data_word;

    assign total_bytes  = {{WORD_W{1'b0}}, line_len} * {{WORD_W{1'b0}}, line_cnt};
    assign target_words = total_bytes >> 2;
    assign done         = armed_q && (ADDR_W'(offset_q) >= target_words);

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_data))
        else $error("stalled request changed"); // R5

    AST_STALL_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> $stable(offset_q))
        else $error("offset moved while stalled"); // R5

    AST_OFS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> offset_q == $past(offset_q) + OFS_W'(1))
        else $error("offset did not step by one"); // R3

    AST_EXEC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fire && is_exec |=> offset_q == '0)
        else $error("execute did not clear offset"); // R4

    AST_REJECT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> !mem_req_valid && err_cfg && $stable(offset_q))
        else $error("rejected data write leaked"); // R6

    AST_BAD_METHOD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fire && !in_range |=> err_method && !mem_req_valid)
        else $error("out-of-range method not flagged"); // R7
endmodule

// File: rtl/inline_wr_engine.sv
module inline_wr_engine #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned METH_W = 8,
    parameter int unsigned OFS_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    output logic                  cmd_ready,
    input  logic [METH_W-1:0]     cmd_method,
    input  logic [WORD_W-1:0]     cmd_data,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic [2*WORD_W-1:0]   mem_req_addr,
    output logic [WORD_W-1:0]     mem_req_data,
    output logic                  done,
    output logic                  err_cfg,
    output logic                  err_method
);
    localparam int unsigned ADDR_W = 2 * WORD_W;

    logic              cmd_fire, exec_linear, origin_zero;
    logic [ADDR_W-1:0] base_addr;
    logic [WORD_W-1:0] line_len, line_cnt, data_word;

    iwe_cfg_regs #(.WORD_W(WORD_W), .METH_W(METH_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cmd_fire), .wr_method(cmd_method), .wr_data(cmd_data),
        .base_addr(base_addr), .line_len(line_len), .line_cnt(line_cnt),
        .exec_linear(exec_linear), .origin_zero(origin_zero), .data_word(data_word)
    );

    iwe_seq #(.WORD_W(WORD_W), .METH_W(METH_W), .OFS_W(OFS_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_method(cmd_method),
        .cmd_ready(cmd_ready), .cmd_fire(cmd_fire),
        .base_addr(base_addr), .line_len(line_len), .line_cnt(line_cnt),
        .exec_linear(exec_linear), .origin_zero(origin_zero), .data_word(data_word),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
        .done(done), .err_cfg(err_cfg), .err_method(err_method)
    );
endmodule

// File: tb/inline_wr_engine_bench.sv
module inline_wr_engine_bench;
    localparam int WW = 32;
    localparam int MW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic            cmd_valid = 1'b0;
    logic [MW-1:0]   cmd_method = '0;
    logic [WW-1:0]   cmd_data = '0;
    logic            cmd_ready, mem_req_valid, mem_req_ready;
    logic [2*WW-1:0] mem_req_addr;
    logic [WW-1:0]   mem_req_data;
    logic            done, err_cfg, err_method;

    logic        stall_mode = 1'b0;
    logic [31:0] cyc = '0;
    always @(posedge clk) cyc <= cyc + 1;
    assign mem_req_ready = stall_mode ? (cyc[1:0] == 2'b11) : 1'b1;

    inline_wr_engine u_inline_wr_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_method(cmd_method), .cmd_data(cmd_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
        .done(done), .err_cfg(err_cfg), .err_method(err_method)
    );

    int nchk = 0;
    int nfail = 0;
    int wcnt = 0;
    bit finished = 1'b0;
    logic [63:0] log_addr [256];
    logic [31:0] log_data [256];

    function automatic void chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endfunction

    // memory-side monitor, sampled on the falling edge
    logic        hold_pend = 1'b0;
    logic [63:0] hold_a;
    logic [31:0] hold_d;
    always @(negedge clk) begin
        if (!rst_n) begin
            hold_pend = 1'b0;
        end else begin
            if (hold_pend) begin
                chk(mem_req_valid && !cmd_ready, "R5 stalled request dropped or cmd_ready high",
                    {62'd0, mem_req_valid, cmd_ready}, 64'd2);
                chk(mem_req_addr == hold_a && mem_req_data == hold_d, "R5 stalled request changed",
                    mem_req_addr, hold_a);
            end
            hold_pend = mem_req_valid && !mem_req_ready;
            hold_a    = mem_req_addr;
            hold_d    = mem_req_data;
            if (mem_req_valid && mem_req_ready) begin
                if (wcnt < 256) begin
                    log_addr[wcnt] = mem_req_addr;
                    log_data[wcnt] = mem_req_data;
                end
                wcnt++;
            end
        end
    end

    task automatic put(input logic [MW-1:0] m, input logic [WW-1:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_method = m; cmd_data = d;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (mem_req_valid) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic setup(input logic [63:0] base, input logic [31:0] len, input logic [31:0] cnt);
        put(8'h60, len);
        put(8'h61, cnt);
        put(8'h62, base[63:32]);
        put(8'h63, base[31:0]);
    endtask

    function automatic logic [31:0] dval(input int k, input int salt);
        return 32'hC0DE0000 ^ (32'(k) * 32'h01010101) ^ 32'(salt << 12);
    endfunction

    task automatic expect_word(input int idx, input logic [63:0] a, input logic [31:0] d, input string tag);
        chk(idx < wcnt && log_addr[idx] == a, tag, log_addr[idx], a);
        chk(idx < wcnt && log_data[idx] == d, tag, {32'd0, log_data[idx]}, {32'd0, d});
    endtask

    task automatic run_stream(input logic [63:0] base, input int n, input int cnt, input bit smode, input int salt);
        int start;
        do_reset();
        stall_mode = smode;
        setup(base, 32'(4 * n / cnt), 32'(cnt));
        chk(done == 1'b0, "R9 done before execute", {63'd0, done}, 64'd0);
        put(8'h6C, 32'h1);
        start = wcnt;
        for (int i = 0; i < n; i++) begin
            wait_idle();
            chk(done == 1'b0, "R9 done early", {63'd0, done}, 64'd0);
            put(8'h6D, dval(i, salt));
        end
        wait_idle();
        chk(wcnt - start == n, "R3 word count", 64'(wcnt - start), 64'(n));
        for (int i = 0; i < n; i++)
            expect_word(start + i, base + 64'(4 * i), dval(i, salt), "R2 R3 stream word");
        chk(done == 1'b1, "R9 done at size", {63'd0, done}, 64'd1);
        chk(!err_cfg && !err_method, "R8 no error on clean stream", {62'd0, err_cfg, err_method}, 64'd0);
        stall_mode = 1'b0;
    endtask

    initial begin
        logic [63:0] bases [2];
        logic [63:0] b;
        int start;
        bases[0] = 64'h0000_0001_2000_0000;
        bases[1] = 64'h0000_0012_FFFF_FFF0;

        do_reset();
        chk(cmd_ready == 1'b1, "R1 cmd_ready after reset", {63'd0, cmd_ready}, 64'd1);
        chk({mem_req_valid, done, err_cfg, err_method} == 4'b0, "R1 outputs after reset",
            {60'd0, mem_req_valid, done, err_cfg, err_method}, 64'd0);

        // sweep: base, length, split, stalls
        for (int bi = 0; bi < 2; bi++)
            for (int n = 1; n <= 5; n++)
                for (int s = 0; s < 2; s++)
                    run_stream(bases[bi], n, (n % 2) + 1, s[0], bi * 16 + n * 2 + s);

        // R4: re-execute in mid-stream rewinds to the base
        b = bases[1];
        do_reset();
        setup(b, 32'd64, 32'd1);
        put(8'h6C, 32'h1);
        start = wcnt;
        for (int i = 0; i < 3; i++) put(8'h6D, dval(i, 7));
        wait_idle();
        put(8'h6C, 32'hFFFF_FFFF);
        for (int i = 0; i < 2; i++) put(8'h6D, dval(i, 8));
        wait_idle();
        expect_word(start + 2, b + 64'd8, dval(2, 7), "R3 before re-execute");
        expect_word(start + 3, b, dval(0, 8), "R4 rewind to base");
        expect_word(start + 4, b + 64'd4, dval(1, 8), "R4 continue after rewind");

        // R6: linear bit clear rejects
        for (int v = 0; v < 2; v++) begin
            do_reset();
            setup(b, 32'd64, 32'd1);
            put(8'h6C, v == 0 ? 32'h0 : 32'h2);
            start = wcnt;
            put(8'h6D, 32'h1234_5678);
            wait_idle();
            chk(wcnt == start, "R6 non-linear write issued", 64'(wcnt - start), 64'd0);
            chk(err_cfg && !err_method, "R6 err_cfg after non-linear", {62'd0, err_cfg, err_method}, 64'd2);
        end

        // R6: nonzero origin in z, x, y rejects and leaves the offset alone
        for (int k = 0; k < 3; k++) begin
            logic [7:0] om;
            om = 8'(8'h69 + k);
            do_reset();
            setup(b, 32'd64, 32'd1);
            put(8'h6C, 32'h1);
            start = wcnt;
            put(8'h6D, dval(0, 20 + k));
            put(om, 32'd5);
            put(8'h6D, 32'hDEAD_BEEF);
            wait_idle();
            chk(wcnt - start == 1, "R6 origin write issued", 64'(wcnt - start), 64'd1);
            chk(err_cfg == 1'b1, "R6 err_cfg after origin", {63'd0, err_cfg}, 64'd1);
            put(om, 32'd0);
            put(8'h6D, dval(1, 20 + k));
            wait_idle();
            expect_word(start, b, dval(0, 20 + k), "R6 word before reject");
            expect_word(start + 1, b + 64'd4, dval(1, 20 + k), "R6 offset kept over reject");
            chk(err_cfg == 1'b1, "R6 err_cfg sticky", {63'd0, err_cfg}, 64'd1);
        end

        // R7 / R8: out-of-range and inert methods
        do_reset();
        setup(b, 32'd8, 32'd1);
        put(8'h6C, 32'h1);
        start = wcnt;
        put(8'h6D, dval(0, 30));
        put(8'h64, 32'hFFFF_FFFF);
        put(8'h00, 32'hFFFF_FFFF);
        put(8'h66, 32'h1);
        put(8'h7E, 32'h1);
        wait_idle();
        chk(wcnt - start == 1, "R8 inert method wrote", 64'(wcnt - start), 64'd1);
        chk({done, err_cfg, err_method} == 3'b000, "R8 inert method changed state",
            {61'd0, done, err_cfg, err_method}, 64'd0);
        put(8'h7F, 32'h1);
        put(8'hFF, 32'h1);
        wait_idle();
        chk(wcnt - start == 1, "R7 out-of-range wrote", 64'(wcnt - start), 64'd1);
        chk(err_method && !err_cfg, "R7 err_method", {62'd0, err_cfg, err_method}, 64'd1);
        put(8'h6D, dval(1, 30));
        wait_idle();
        expect_word(start + 1, b + 64'd4, dval(1, 30), "R7 R8 offset untouched");
        chk(done == 1'b1, "R9 done after two words", {63'd0, done}, 64'd1);
        chk(err_method == 1'b1, "R7 err_method sticky", {63'd0, err_method}, 64'd1);

        // R9: byte count not a multiple of four floors
        do_reset();
        setup(b, 32'd10, 32'd1);
        put(8'h6C, 32'h1);
        put(8'h6D, 32'h1);
        wait_idle();
        chk(done == 1'b0, "R9 floor one word", {63'd0, done}, 64'd0);
        put(8'h6D, 32'h2);
        wait_idle();
        chk(done == 1'b1, "R9 floor two words", {63'd0, done}, 64'd1);
        put(8'h6D, 32'h3);
        wait_idle();
        chk(done == 1'b1, "R9 done past size", {63'd0, done}, 64'd1);

        // R9: zero size is done at execute, not before
        do_reset();
        setup(b, 32'd0, 32'd3);
        chk(done == 1'b0, "R9 zero size before execute", {63'd0, done}, 64'd0);
        put(8'h6C, 32'h1);
        chk(done == 1'b1, "R9 zero size after execute", {63'd0, done}, 64'd1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule